// File: doc/BRIEF.md
# Long Multiply-Accumulate Execution Unit

This unit executes the long multiply family of a processor's integer pipeline. It multiplies two register values into a double-width product and can add a double-width addend to it. The unit handles signed and unsigned operands, each with or without accumulation. It takes the decoded instruction word, the condition result worked out upstream, and four register read values: the two operands and the current contents of the high and low destination registers. It returns both result words, their destination register numbers, write enables and the updated negative and zero flags.

The datapath is iterative. A single-cycle `start` captures every input, including the addend, so the register file can keep changing while the multiply runs. The multiplier retires `STEP_W` bits per cycle. A write-back cycle then presents the result with a one-cycle `done` pulse. Instructions whose condition failed, and encodings that are malformed, finish one cycle after `start` and write nothing.

Top module: `lmul_unit`

## Requirements
- R1: The instruction word is decoded as follows. Bit 22 set means signed and clear means unsigned. Bit 21 set means accumulate. Bit 20 set means update the flags. Bits 19:16 name the high destination and bits 15:12 name the low destination. Outputs `hi_idx` and `lo_idx` carry these two numbers, and the writes carry them too.
- R2: With bits 22 and 21 clear, {hi_data, lo_data} equals rm_val × rs_val, with both operands taken as unsigned. The low half of the product goes to `lo_data` and the high half goes to `hi_data`.
- R3: With bit 22 set and bit 21 clear, {hi_data, lo_data} is the two's-complement product of rm_val and rs_val, with both taken as signed.
- R4: With bit 21 set, the result is the product plus {hi_val, lo_val}, taken modulo 2^(2·DATA_W). The product follows the signedness that bit 22 selects.
- R5: Operands, addend, instruction and incoming flags are sampled only on an accepted `start`. Later changes to these inputs have no effect on the result. A `start` that arrives while `busy` is high is ignored.
- R6: With bit 20 set, `flag_we` pulses with `done`. `flag_n` then equals bit 2·DATA_W−1 of the result, and `flag_z` is 1 only when every result bit is 0. With bit 20 clear, `flag_we` stays 0 and `flag_n` and `flag_z` echo the `n_in` and `z_in` values that were sampled at start.
- R7: When `cond_pass` is low at start, `done` pulses in the next cycle. In that cycle `hi_we`, `lo_we`, `flag_we` and `dec_err` are all 0.
- R8: `dec_err` pulses with `done`, one cycle after start, in two cases. The first is when bits 27:23 are not 00001 or bits 7:4 are not 1001. The second is when bits 19:16 equal bits 15:12. In either case no write enable or flag enable is raised.
- R9: On an executing instruction, `busy` is high from the cycle after start until `done`. `done` is high for exactly one cycle, STEPS+1 cycles after the start edge, where STEPS = DATA_W/STEP_W. `hi_we` and `lo_we` pulse only together with `done`.
- R10: After reset, `done`, `busy`, `dec_err`, `hi_we`, `lo_we` and `flag_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue pulse; accepted when not busy |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition evaluated true |
| rm_val | input | DATA_W | First operand register value |
| rs_val | input | DATA_W | Second operand register value |
| hi_val | input | DATA_W | Current high destination value (addend high word) |
| lo_val | input | DATA_W | Current low destination value (addend low word) |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| dec_err | output | 1 | Malformed encoding, pulses with done |
| hi_we | output | 1 | High result write enable |
| lo_we | output | 1 | Low result write enable |
| hi_idx | output | 4 | High destination register number |
| lo_idx | output | 4 | Low destination register number |
| hi_data | output | DATA_W | High result word |
| lo_data | output | DATA_W | Low result word |
| flag_we | output | 1 | Flag write enable |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |

## Verification
The bench builds the unit with DATA_W=4 and STEP_W=2. At that size every operand pair can be swept in all four variants, and the accumulate forms can be run against several addends, including ones that carry into the high word and wrap around. Two iteration steps per multiply exercise the shift and sum path across more than one cycle. The narrow result word makes the zero and negative flag cases common in the sweep.

// File: rtl/lmul_pkg.sv
package lmul_pkg;

    typedef struct packed {
        logic [3:0] hi_idx;
        logic [3:0] lo_idx;
        logic       sgn;
        logic       acc;
        logic       setf;
        logic       bad;
    } lmul_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WB   = 2'd2
    } lmul_state_e;

endpackage

// File: rtl/lmul_decode.sv
module lmul_decode
    import lmul_pkg::*;
(
    input  logic [31:0] instr,
    output lmul_dec_t   dec
);
    localparam logic [4:0] FIX_HI = 5'b00001;
    localparam logic [3:0] FIX_LO = 4'b1001;

    always_comb begin
        dec.hi_idx = instr[19:16];
        dec.lo_idx = instr[15:12];
        dec.sgn    = instr[22];
        dec.acc    = instr[21];
        dec.setf   = instr[20];
        dec.bad    = (instr[27:23] != FIX_HI) || (instr[7:4] != FIX_LO)
                   || (instr[19:16] == instr[15:12]);
    end
endmodule

// File: rtl/lmul_flags.sv
module lmul_flags #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] res,
    output logic           neg,
    output logic           zero
);
    always_comb begin
        neg  = res[2*W-1];
        zero = (res == '0);
    end
endmodule

// File: rtl/lmul_iter.sv
module lmul_iter #(
    parameter int W      = 32,
    parameter int STEP_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic           is_signed,
    input  logic [2*W-1:0] addend,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic [PW-1:0] acc;
        logic [PW-1:0] mc;
        logic [W-1:0]  mp;
    } core_t;

    core_t core_d, core_q;

    logic [PW-1:0] term [STEP_W];
    logic [PW-1:0] step_sum;
    logic [PW-1:0] corr;

    genvar g;
    generate
        for (g = 0; g < STEP_W; g++) begin : g_term
            assign term[g] = core_q.mp[g] ? (core_q.mc << g) : '0;
        end
    endgenerate

    always_comb begin
        step_sum = '0;
        for (int i = 0; i < STEP_W; i++) begin
            step_sum = step_sum + term[i];
        end
    end

    // Signed correction: subtract the other operand shifted up one word for each negative input.
    always_comb begin
        corr = '0;
        if (is_signed && op_a[W-1]) corr = corr + {op_b, {W{1'b0}}};
        if (is_signed && op_b[W-1]) corr = corr + {op_a, {W{1'b0}}};
    end

    always_comb begin
        core_d = core_q;
        if (load) begin
            core_d.acc = addend - corr;
            core_d.mc  = {{W{1'b0}}, op_a};
            core_d.mp  = op_b;
        end else if (step) begin
            core_d.acc = core_q.acc + step_sum;
            core_d.mc  = core_q.mc << STEP_W;
            core_d.mp  = core_q.mp >> STEP_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign prod = core_q.acc;
endmodule

// File: rtl/lmul_unit.sv
module lmul_unit
    import lmul_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic              cond_pass,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] hi_val,
    input  logic [DATA_W-1:0] lo_val,
    input  logic              n_in,
    input  logic              z_in,
    output logic              busy,
    output logic              done,
    output logic              dec_err,
    output logic              hi_we,
    output logic              lo_we,
    output logic [3:0]        hi_idx,
    output logic [3:0]        lo_idx,
    output logic [DATA_W-1:0] hi_data,
    output logic [DATA_W-1:0] lo_data,
    output logic              flag_we,
    output logic              flag_n,
    output logic              flag_z
);
    localparam int STEPS = DATA_W / STEP_W;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam int PW    = 2 * DATA_W;

    typedef struct packed {
        lmul_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        hi_idx;
        logic [3:0]        lo_idx;
        logic              setf;
        logic              n_cap;
        logic              z_cap;
        logic              done;
        logic              err;
        logic              we;
        logic              fwe;
        logic              fn;
        logic              fz;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } top_t;

    top_t          r_d, r_q;
    lmul_dec_t     dec;
    logic          accept;
    logic          load;
    logic          step;
    logic [PW-1:0] addend;
    logic [PW-1:0] prod;
    logic          res_n;
    logic          res_z;

    lmul_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign accept = start && (r_q.st == ST_IDLE);
    assign load   = accept && !dec.bad && cond_pass;
    assign step   = (r_q.st == ST_RUN);
    assign addend = dec.acc ? {hi_val, lo_val} : '0;

    lmul_iter #(
        .W      (DATA_W),
        .STEP_W (STEP_W)
    ) u_iter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .op_a      (rm_val),
        .op_b      (rs_val),
        .is_signed (dec.sgn),
        .addend    (addend),
        .prod      (prod)
    );

    lmul_flags #(.W(DATA_W)) u_flags (
        .res  (prod),
        .neg  (res_n),
        .zero (res_z)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        r_d.we   = 1'b0;
        r_d.fwe  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.hi_idx = dec.hi_idx;
                    r_d.lo_idx = dec.lo_idx;
                    r_d.setf   = dec.setf;
                    r_d.n_cap  = n_in;
                    r_d.z_cap  = z_in;
                    r_d.fn     = n_in;
                    r_d.fz     = z_in;
                    r_d.cnt    = '0;
                    if (dec.bad) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else if (!cond_pass) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(STEPS - 1)) r_d.st = ST_WB;
            end
            ST_WB: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                r_d.we   = 1'b1;
                r_d.hi   = prod[PW-1:DATA_W];
                r_d.lo   = prod[DATA_W-1:0];
                if (r_q.setf) begin
                    r_d.fwe = 1'b1;
                    r_d.fn  = res_n;
                    r_d.fz  = res_z;
                end else begin
                    r_d.fn  = r_q.n_cap;
                    r_d.fz  = r_q.z_cap;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign dec_err = r_q.err;
    assign hi_we   = r_q.we;
    assign lo_we   = r_q.we;
    assign hi_idx  = r_q.hi_idx;
    assign lo_idx  = r_q.lo_idx;
    assign hi_data = r_q.hi;
    assign lo_data = r_q.lo;
    assign flag_we = r_q.fwe;
    assign flag_n  = r_q.fn;
    assign flag_z  = r_q.fz;
endmodule

// File: rtl/lmul_unit_chk.sv
module lmul_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cond_pass,
    input logic              busy,
    input logic              done,
    input logic              dec_err,
    input logic              hi_we,
    input logic              lo_we,
    input logic [3:0]        hi_idx,
    input logic [3:0]        lo_idx,
    input logic [DATA_W-1:0] hi_data,
    input logic [DATA_W-1:0] lo_data,
    input logic              flag_we,
    input logic              flag_n,
    input logic              flag_z
);
    // R7
    a_r7_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !cond_pass) |=> (done && !hi_we && !lo_we && !flag_we));

    // R8
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (done && !hi_we && !lo_we && !flag_we));

    // R9
    a_r9_we_paired: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we || lo_we) |-> (hi_we && lo_we && done));

    // R9
    a_r9_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R6
    a_r6_flag_values: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (done && flag_n == hi_data[DATA_W-1]
                     && flag_z == ({hi_data, lo_data} == '0)));

    // R1
    a_r1_distinct_dest: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |-> (hi_idx != lo_idx));

    // R10
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r10_reset_quiet: assert (!done && !hi_we && !flag_we && !dec_err);
        end
    end
endmodule

bind lmul_unit lmul_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cond_pass (cond_pass),
    .busy      (busy),
    .done      (done),
    .dec_err   (dec_err),
    .hi_we     (hi_we),
    .lo_we     (lo_we),
    .hi_idx    (hi_idx),
    .lo_idx    (lo_idx),
    .hi_data   (hi_data),
    .lo_data   (lo_data),
    .flag_we   (flag_we),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
);

// File: tb/lmul_unit_tb.sv
module lmul_unit_tb;
    localparam int W     = 4;
    localparam int SW    = 2;
    localparam int STEPS = W / SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   instr = '0;
    logic          cond_pass = 1'b1;
    logic [W-1:0]  rm_val = '0, rs_val = '0, hi_val = '0, lo_val = '0;
    logic          n_in = 1'b0, z_in = 1'b0;
    logic          busy, done, dec_err, hi_we, lo_we, flag_we, flag_n, flag_z;
    logic [3:0]    hi_idx, lo_idx;
    logic [W-1:0]  hi_data, lo_data;

    int errors = 0;
    int checks = 0;
    int lat;

    always #5 clk = ~clk;

    lmul_unit #(.DATA_W(W), .STEP_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .cond_pass(cond_pass), .rm_val(rm_val), .rs_val(rs_val),
        .hi_val(hi_val), .lo_val(lo_val), .n_in(n_in), .z_in(z_in),
        .busy(busy), .done(done), .dec_err(dec_err), .hi_we(hi_we),
        .lo_we(lo_we), .hi_idx(hi_idx), .lo_idx(lo_idx),
        .hi_data(hi_data), .lo_data(lo_data), .flag_we(flag_we),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit s, input bit a, input bit f,
                                       input logic [3:0] hd, input logic [3:0] ld);
        return {4'hE, 5'b00001, s, a, f, hd, ld, 4'h2, 4'b1001, 4'h1};
    endfunction

    function automatic logic [2*W-1:0] model(input bit s, input bit a,
        input logic [W-1:0] x, input logic [W-1:0] y,
        input logic [W-1:0] h, input logic [W-1:0] l);
        int xv, yv, r;
        xv = (s && x[W-1]) ? int'(x) - (1 << W) : int'(x);
        yv = (s && y[W-1]) ? int'(y) - (1 << W) : int'(y);
        r  = xv * yv + (a ? int'({h, l}) : 0);
        return r[2*W-1:0];
    endfunction

    // Issue one instruction and wait for done; lat = negedges after start release.
    task automatic issue(input logic [31:0] ins, input bit cp,
                         input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [W-1:0] h, input logic [W-1:0] l,
                         input bit ni, input bit zi);
        @(negedge clk);
        instr = ins; cond_pass = cp; rm_val = x; rs_val = y;
        hi_val = h; lo_val = l; n_in = ni; z_in = zi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [2*W-1:0] e;
        logic [W-1:0] adds [4];
        adds[0] = 4'h0; adds[1] = 4'hF; adds[2] = 4'h8; adds[3] = 4'h3;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!done && !busy && !dec_err && !hi_we && !lo_we && !flag_we, "R10",
            {done, busy, dec_err, hi_we, flag_we}, 0);
        rst_n = 1'b1;

        // R2 R3 R4 R1 R6 R9 exhaustive sweep
        for (int v = 0; v < 4; v++) begin
            for (int x = 0; x < (1 << W); x++) begin
                for (int y = 0; y < (1 << W); y++) begin
                    for (int k = 0; k < ((v & 1) ? 4 : 1); k++) begin
                        bit s = v[1];
                        bit a = v[0];
                        logic [W-1:0] h = adds[k];
                        logic [W-1:0] l = adds[3-k];
                        issue(mk(s, a, 1'b1, 4'd7, 4'd3), 1'b1, W'(x), W'(y), h, l, 1'b0, 1'b0);
                        e = model(s, a, W'(x), W'(y), h, l);
                        chk({hi_data, lo_data} == e,
                            a ? "R4 accumulate" : (s ? "R3 signed" : "R2 unsigned"),
                            {hi_data, lo_data}, e);
                        chk(lat == STEPS + 1 && hi_we && lo_we && !dec_err, "R9 latency",
                            lat, STEPS + 1);
                        chk(flag_we && flag_n == e[2*W-1] && flag_z == (e == 0), "R6 flags",
                            {flag_we, flag_n, flag_z}, {1'b1, e[2*W-1], e == 0});
                        chk(hi_idx == 4'd7 && lo_idx == 4'd3, "R1 indices",
                            {hi_idx, lo_idx}, 8'h73);
                        @(negedge clk);
                        chk(!done && !hi_we, "R9 one-cycle done", done, 0);
                    end
                end
            end
        end

        // R1 field swap: different destinations
        issue(mk(1'b0, 1'b0, 1'b0, 4'd2, 4'd9), 1'b1, 4'h3, 4'h5, 4'h0, 4'h0, 1'b1, 1'b1);
        chk(hi_idx == 4'd2 && lo_idx == 4'd9 && {hi_data, lo_data} == 8'd15, "R1 fields",
            {hi_idx, lo_idx, hi_data, lo_data}, 16'h290F);
        // R6 no flag update: echo inputs
        chk(!flag_we && flag_n && flag_z, "R6 flags held", {flag_we, flag_n, flag_z}, 3);

        // R7 condition fail
        issue(mk(1'b0, 1'b1, 1'b1, 4'd1, 4'd0), 1'b0, 4'h3, 4'h3, 4'h1, 4'h1, 1'b0, 1'b1);
        chk(lat == 0 && !hi_we && !lo_we && !flag_we && !dec_err, "R7 cond fail",
            {lat[3:0], hi_we, flag_we, dec_err}, 0);
        chk(!flag_n && flag_z, "R7 flags unchanged", {flag_n, flag_z}, 1);

        // R8 bad fixed bits
        issue(mk(1'b0, 1'b0, 1'b1, 4'd1, 4'd0) ^ 32'h0080_0000, 1'b1, 4'h3, 4'h3, 4'h0, 4'h0, 1'b0, 1'b0);
        chk(lat == 0 && dec_err && !hi_we && !flag_we, "R8 opcode", {dec_err, hi_we}, 2);
        issue(mk(1'b0, 1'b0, 1'b1, 4'd1, 4'd0) ^ 32'h0000_0040, 1'b1, 4'h3, 4'h3, 4'h0, 4'h0, 1'b0, 1'b0);
        chk(lat == 0 && dec_err && !hi_we && !flag_we, "R8 low fixed", {dec_err, hi_we}, 2);
        // R8 same destination
        issue(mk(1'b0, 1'b0, 1'b1, 4'd5, 4'd5), 1'b1, 4'h3, 4'h3, 4'h0, 4'h0, 1'b0, 1'b0);
        chk(lat == 0 && dec_err && !hi_we && !flag_we, "R8 same dest", {dec_err, hi_we}, 2);

        // R5 inputs change mid-run, second start ignored
        @(negedge clk);
        instr = mk(1'b1, 1'b1, 1'b1, 4'd4, 4'd6); cond_pass = 1'b1;
        rm_val = 4'hD; rs_val = 4'h6; hi_val = 4'h2; lo_val = 4'h9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R9 busy", busy, 1);
        rm_val = 4'h1; rs_val = 4'h1; hi_val = 4'h0; lo_val = 4'h0;
        instr = mk(1'b0, 1'b0, 1'b1, 4'd8, 4'd9);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        e = model(1'b1, 1'b1, 4'hD, 4'h6, 4'h2, 4'h9);
        chk({hi_data, lo_data} == e && hi_idx == 4'd4, "R5 captured", {hi_data, lo_data}, e);
        repeat (6) @(negedge clk);
        chk(!done && !busy, "R5 busy start ignored", {done, busy}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule